// File: doc/BRIEF.md
# Address Strobe Stretch Controller

This block runs the timing of single external memory accesses. A requester presents a 22-bit address, a direction flag and write data. When the block accepts the request it drives the address onto the external bus and raises the address strobe. The strobe is held for one base cycle plus a programmable number of wait cycles. One data cycle follows, in which the block pulses the read or write control. In the cycle after that it reports completion with a one-cycle done pulse. For reads, the captured data is valid in the same cycle as the done pulse.

The number of wait cycles comes from an 8-bit configuration register that holds two independent 2-bit fields. The top address bit divides the address space into a lower half and an upper half, and each half has its own field. That bit is therefore sampled, together with the field it selects, at the moment a request is accepted. While an access is running, the block holds further requests off by keeping its ready output low.

Top module: `as_stretch_ctrl`

## Requirements
- R1: After reset the configuration reads 0x1F, so both stretch fields are 3. In the reset state the strobe is low, ready is high and done is low. The first access after reset holds the strobe for 4 cycles.
- R2: Configuration readback has bit 4 fixed at 1 and bits 7:5 fixed at 0. The lower-half field is stored in bits 3:2 and the upper-half field in bits 1:0. Writes to bits 7:4 have no effect.
- R3: An accepted request with address bit 21 at 0 holds `ext_as` high for 1 + (lower field) consecutive cycles, starting in the cycle after acceptance.
- R4: An accepted request with address bit 21 at 1 holds `ext_as` high for 1 + (upper field) consecutive cycles, starting in the cycle after acceptance.
- R5: The cycle right after the strobe phase is a single data cycle with `ext_as` low. In it, `ext_rd` is high for a read or `ext_wr` is high for a write, and the two are never high together. `ext_addr` shows the request address through the whole strobe phase and the data cycle.
- R6: `done` is high for exactly one cycle, the cycle after the data cycle. For a stretch of 0 the access occupies two cycles before done. For a read, `rd_data` equals the `ext_rdata` value present during the data cycle.
- R7: `req_ready` is low from the first strobe cycle through the data cycle, and is high again in the done cycle. A request held valid while ready is low starts no access.
- R8: The stretch count is fixed when the request is accepted. A configuration write made during an access does not change the timing of that access.
- R9: For a write, `ext_data_oe` is high and `ext_wdata` shows the write data only during the data cycle. For a read, `ext_data_oe` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_wdata | input | 8 | Configuration write value |
| cfg_rdata | output | 8 | Configuration readback |
| req_valid | input | 1 | Access request |
| req_ready | output | 1 | High when a request can be accepted |
| req_addr | input | 22 | Access address; bit 21 selects the stretch field |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 8 | Write data |
| ext_as | output | 1 | Address strobe, active high |
| ext_addr | output | 22 | External address bus |
| ext_rd | output | 1 | Read control, high in the data cycle of a read |
| ext_wr | output | 1 | Write control, high in the data cycle of a write |
| ext_data_oe | output | 1 | Data bus output enable |
| ext_wdata | output | 8 | Data driven to the bus |
| ext_rdata | input | 8 | Data returned by the bus |
| rd_data | output | 8 | Captured read data |
| done | output | 1 | One-cycle completion pulse |

## Verification
A wrong wait counter, or the wrong half selected, shows up as a strobe that is too long or too short. Either error is visible at `ext_as` within the first access of that configuration. A sequencer stuck in a phase shows at once as a missing done pulse or a ready output that stays low, in the cycle where the pulse was due. A lost capture or field mix-up shows as a wrong `rd_data` or a wrong strobe length in the same access. The bench sweeps every field value in both halves for reads and writes. On alternate accesses it disturbs the configuration and holds an extra request during the access.

// File: rtl/as_stretch_pkg.sv
package as_stretch_pkg;
  localparam int STRETCH_W   = 2;
  localparam int CFG_W       = 8;
  localparam int NUM_HALVES  = 2;
  localparam int LO_FIELD_LSB = 2;
  localparam int UP_FIELD_LSB = 0;
  localparam int FIXED_ONE_BIT = 4;
  localparam logic [STRETCH_W-1:0] STRETCH_RESET = '1;
  localparam int MAX_STRETCH = (1 << STRETCH_W) - 1;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2
  } phase_t;
endpackage

// File: rtl/as_cfg_reg.sv
module as_cfg_reg
  import as_stretch_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 we,
  input  logic [CFG_W-1:0]     wdata,
  output logic [CFG_W-1:0]     rdata,
  output logic [STRETCH_W-1:0] lo_field,
  output logic [STRETCH_W-1:0] up_field
);
  localparam int FIELD_LSB [NUM_HALVES] = '{LO_FIELD_LSB, UP_FIELD_LSB};

  logic [STRETCH_W-1:0] field_q [NUM_HALVES];

  genvar h;
  generate
    for (h = 0; h < NUM_HALVES; h++) begin : g_field
      always_ff @(posedge clk) begin
        if (rst) begin
          field_q[h] <= STRETCH_RESET;
        end else if (we) begin
          field_q[h] <= wdata[FIELD_LSB[h] +: STRETCH_W];
        end
      end
    end
  endgenerate

  assign lo_field = field_q[0];
  assign up_field = field_q[1];

  always_comb begin
    rdata = '0;
    rdata[FIXED_ONE_BIT] = 1'b1;
    rdata[LO_FIELD_LSB +: STRETCH_W] = field_q[0];
    rdata[UP_FIELD_LSB +: STRETCH_W] = field_q[1];
  end

  logic unused_cfg_bits;
  assign unused_cfg_bits = ^wdata[CFG_W-1:FIXED_ONE_BIT];

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable({lo_field, up_field})); // R2
endmodule

// File: rtl/as_stretch_sel.sv
module as_stretch_sel
  import as_stretch_pkg::*;
(
  input  logic                 upper_half,
  input  logic [STRETCH_W-1:0] lo_field,
  input  logic [STRETCH_W-1:0] up_field,
  output logic [STRETCH_W-1:0] stretch
);
  always_comb begin
    stretch = upper_half ? up_field : lo_field;
  end
endmodule

// File: rtl/as_cycle_fsm.sv
module as_cycle_fsm
  import as_stretch_pkg::*;
#(
  parameter int ADDR_W = 22,
  parameter int DATA_W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic                 req_write,
  input  logic [DATA_W-1:0]    req_wdata,
  input  logic [STRETCH_W-1:0] stretch,
  input  logic [DATA_W-1:0]    ext_rdata,
  output logic                 req_ready,
  output logic                 ext_as,
  output logic [ADDR_W-1:0]    ext_addr,
  output logic                 ext_rd,
  output logic                 ext_wr,
  output logic                 ext_data_oe,
  output logic [DATA_W-1:0]    ext_wdata,
  output logic [DATA_W-1:0]    rd_data,
  output logic                 done
);
  localparam int RUN_W = STRETCH_W + 1;

  phase_t               phase_q;
  logic [STRETCH_W-1:0] wait_q;
  logic                 write_q;
  logic                 as_q, rd_q, wr_q, oe_q, done_q, ready_q;
  logic [ADDR_W-1:0]    addr_q;
  logic [DATA_W-1:0]    wdata_q, rdata_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      wait_q  <= '0;
      write_q <= 1'b0;
      as_q    <= 1'b0;
      rd_q    <= 1'b0;
      wr_q    <= 1'b0;
      oe_q    <= 1'b0;
      done_q  <= 1'b0;
      ready_q <= 1'b1;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (phase_q)
        PH_IDLE: begin
          if (req_valid && ready_q) begin
            phase_q <= PH_ADDR;
            wait_q  <= stretch;
            write_q <= req_write;
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            as_q    <= 1'b1;
            ready_q <= 1'b0;
          end
        end
        PH_ADDR: begin
          if (wait_q == '0) begin
            phase_q <= PH_DATA;
            as_q    <= 1'b0;
            rd_q    <= !write_q;
            wr_q    <= write_q;
            oe_q    <= write_q;
          end else begin
            wait_q <= wait_q - 1'b1;
          end
        end
        PH_DATA: begin
          phase_q <= PH_IDLE;
          rd_q    <= 1'b0;
          wr_q    <= 1'b0;
          oe_q    <= 1'b0;
          done_q  <= 1'b1;
          ready_q <= 1'b1;
          if (!write_q) rdata_q <= ext_rdata;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign req_ready   = ready_q;
  assign ext_as      = as_q;
  assign ext_addr    = addr_q;
  assign ext_rd      = rd_q;
  assign ext_wr      = wr_q;
  assign ext_data_oe = oe_q;
  assign ext_wdata   = wdata_q;
  assign rd_data     = rdata_q;
  assign done        = done_q;

  // Length of the current strobe run, counted independently of wait_q
  logic [RUN_W-1:0] as_run_q;
  always_ff @(posedge clk) begin
    if (rst)       as_run_q <= '0;
    else if (as_q) as_run_q <= as_run_q + 1'b1;
    else           as_run_q <= '0;
  end

  AST_STROBE_WIDTH: assert property (@(posedge clk) disable iff (rst)
    as_q |-> (as_run_q <= RUN_W'(MAX_STRETCH))); // R3
  AST_NO_RD_WR_OVERLAP: assert property (@(posedge clk) disable iff (rst)
    !(rd_q && wr_q)); // R5
  AST_STROBE_THEN_DATA: assert property (@(posedge clk) disable iff (rst)
    $fell(as_q) |-> (rd_q || wr_q)); // R5
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
    ((as_q || rd_q || wr_q) && $past(as_q)) |-> $stable(addr_q)); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q); // R6
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    (as_q || rd_q || wr_q) |-> !ready_q); // R7
  AST_OE_ONLY_WRITE: assert property (@(posedge clk) disable iff (rst)
    oe_q |-> wr_q); // R9
endmodule

// File: rtl/as_stretch_ctrl.sv
module as_stretch_ctrl
  import as_stretch_pkg::*;
#(
  parameter int ADDR_W = 22,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic [CFG_W-1:0]  cfg_rdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              ext_as,
  output logic [ADDR_W-1:0] ext_addr,
  output logic              ext_rd,
  output logic              ext_wr,
  output logic              ext_data_oe,
  output logic [DATA_W-1:0] ext_wdata,
  input  logic [DATA_W-1:0] ext_rdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              done
);
  localparam int HALF_BIT = ADDR_W - 1;

  logic [STRETCH_W-1:0] lo_field, up_field, stretch;

  as_cfg_reg u_cfg (
    .clk      (clk),
    .rst      (rst),
    .we       (cfg_we),
    .wdata    (cfg_wdata),
    .rdata    (cfg_rdata),
    .lo_field (lo_field),
    .up_field (up_field)
  );

  as_stretch_sel u_sel (
    .upper_half (req_addr[HALF_BIT]),
    .lo_field   (lo_field),
    .up_field   (up_field),
    .stretch    (stretch)
  );

  as_cycle_fsm #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_addr    (req_addr),
    .req_write   (req_write),
    .req_wdata   (req_wdata),
    .stretch     (stretch),
    .ext_rdata   (ext_rdata),
    .req_ready   (req_ready),
    .ext_as      (ext_as),
    .ext_addr    (ext_addr),
    .ext_rd      (ext_rd),
    .ext_wr      (ext_wr),
    .ext_data_oe (ext_data_oe),
    .ext_wdata   (ext_wdata),
    .rd_data     (rd_data),
    .done        (done)
  );
endmodule

// File: tb/as_stretch_ctrl_test.sv
module as_stretch_ctrl_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_wdata = '0;
  logic [7:0]  cfg_rdata;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [21:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic [7:0]  req_wdata = '0;
  logic        ext_as, ext_rd, ext_wr, ext_data_oe, done;
  logic [21:0] ext_addr;
  logic [7:0]  ext_wdata, rd_data;
  logic [7:0]  ext_rdata = '0;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  as_stretch_ctrl uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_write(req_write),
    .req_wdata(req_wdata), .ext_as(ext_as), .ext_addr(ext_addr), .ext_rd(ext_rd),
    .ext_wr(ext_wr), .ext_data_oe(ext_data_oe), .ext_wdata(ext_wdata), .ext_rdata(ext_rdata),
    .rd_data(rd_data), .done(done)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [7:0] v);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // One access; n is the expected stretch, disturb adds a mid-access cfg write
  // and a held request while busy.
  task automatic run_access(input logic [21:0] a, input logic w, input logic [7:0] d,
                            input int n, input bit disturb, input string as_tag);
    int as_cnt = 0, as_bad = 0, dp_bad = 0, addr_bad = 0, oe_bad = 0;
    int done_bad = 0, rdat_bad = 0, rdy_bad = 0;
    logic [7:0] exp_rd;
    exp_rd = a[7:0] ^ 8'h5A;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_write = w; req_wdata = d; ext_rdata = exp_rd;
    for (int k = 1; k <= n + 4; k++) begin
      @(negedge clk);
      if (ext_as) as_cnt++;
      if (ext_as != (k <= n + 1)) as_bad++;
      if (k == n + 2) begin
        if (ext_rd != !w || ext_wr != w) dp_bad++;
        if (ext_data_oe != w) oe_bad++;
        if (w && ext_wdata != d) oe_bad++;
      end else begin
        if (ext_rd || ext_wr) dp_bad++;
        if (ext_data_oe) oe_bad++;
      end
      if (k <= n + 2 && ext_addr != a) addr_bad++;
      if (done != (k == n + 3)) done_bad++;
      if (k == n + 3 && !w && rd_data != exp_rd) rdat_bad++;
      if (req_ready != (k >= n + 3)) rdy_bad++;
      if (k == 1) begin
        if (disturb) begin
          req_addr = a ^ 22'h3; req_write = !w;
          cfg_we = 1'b1; cfg_wdata = {4'h1, 2'(3 - n), 2'(3 - n)};
        end else begin
          req_valid = 1'b0;
        end
      end else begin
        cfg_we = 1'b0;
      end
      if (k == n + 1) req_valid = 1'b0;
    end
    check(as_bad == 0 && as_cnt == n + 1, as_tag, as_cnt, n + 1);
    if (disturb) check(as_cnt == n + 1, "R8 timing held across cfg write", as_cnt, n + 1);
    check(dp_bad == 0 && addr_bad == 0, "R5 data cycle and address hold", dp_bad + addr_bad, 0);
    check(oe_bad == 0, "R9 write data enable", oe_bad, 0);
    check(done_bad == 0, "R6 done pulse", done_bad, 0);
    if (!w) check(rdat_bad == 0, "R6 read data", rd_data, exp_rd);
    check(rdy_bad == 0, "R7 ready low while busy", rdy_bad, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(cfg_rdata == 8'h1F, "R1 cfg reset value", cfg_rdata, 8'h1F);
    check(!ext_as && req_ready && !done, "R1 idle outputs", {ext_as, req_ready, done}, 3'b010);
    run_access(22'h000123, 1'b0, 8'h00, 3, 1'b0, "R1 R3 reset lower stretch");
    run_access(22'h200456, 1'b1, 8'h3C, 3, 1'b0, "R1 R4 reset upper stretch");

    write_cfg(8'hFF);
    check(cfg_rdata == 8'h1F, "R2 readback of 0xFF", cfg_rdata, 8'h1F);
    write_cfg(8'h00);
    check(cfg_rdata == 8'h10, "R2 readback of 0x00", cfg_rdata, 8'h10);
    write_cfg(8'hE6);
    check(cfg_rdata == 8'h16, "R2 readback of 0xE6", cfg_rdata, 8'h16);

    for (int lo = 0; lo < 4; lo++) begin
      for (int up = 0; up < 4; up++) begin
        for (int m = 0; m < 4; m++) begin
          logic        hi_half;
          logic        wr;
          logic [21:0] adr;
          hi_half = m[1];
          wr = m[0];
          write_cfg({4'h0, 2'(lo), 2'(up)});
          adr = {hi_half, 21'(lo * 4096 + up * 64 + m * 5 + 1)};
          run_access(adr, wr, 8'(lo * 16 + up * 4 + m), hi_half ? up : lo, m[0] ^ m[1],
                     hi_half ? "R4 upper stretch" : "R3 lower stretch");
        end
      end
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule